// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block arbitrates the interrupt requests of a small embedded processor core. Eleven primary sources are paired into six priority groups. Each group gets one of four levels from two 6-bit priority words: the high word supplies the upper bit of the level and the low word supplies the lower bit. The block picks the winning source and takes it. In the cycle after the take it pulses a strobe and presents a 4-bit vector index and the level that was taken. It also keeps a 4-bit in-service vector, so that only a strictly higher level can nest over the one being serviced. A return pulse from the core retires the highest level in service.

Two of the primary sources are not direct lines. Each is the OR of four sub-sources. A fifth-group source also folds in two serial-peripheral sub-sources, one for the SPI controller and one for the non-volatile memory controller. Every sub-source has a sticky flag and its own enable. A flag is set by a one-cycle event pulse, and software clears it with a clear pulse. A global enable gates every request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `in_svc_o` is 0 and every bit of `sub_flag_o` is 0.
- R2: A pulse on `sub_evt_i[i]` sets `sub_flag_o[i]` at the next clock edge, whatever the state of `sub_en_i[i]`. When an event and a clear arrive in the same cycle, the event wins.
- R3: A set flag stays set until a pulse on `sub_clr_i[i]`. It then reads 0 from the following edge.
- R4: A sub-source raises its combined request only when its flag and its enable are both 1. Bits 0..3 combine into the source with vector 10. Bits 4..7 combine into vector 3. Bits 8..9 are ORed with `direct_req_i[8]` into vector 9.
- R5: The level of group g is `{prio_hi_i[g], prio_lo_i[g]}`, where 3 is the highest. A pending group at a higher level wins over any group at a lower level.
- R6: Among pending groups at the same level, the lowest group number wins. Within a group, the even vector wins. The vector index is 2*g + member. The vector map is: 0 ext0, 1 ser1, 2 tmr0, 3 ext2, 4 ext1, 5 ext3, 6 tmr1, 7 ext4, 8 ser0, 9 ext5, 10 ext6. Direct bits 0..8 map to vectors 0,1,2,4,5,6,7,8,9.
- R7: While `glob_en_i` is 0, no request is taken and `in_svc_o` gains no bit.
- R8: A request is taken only if its level is strictly above every bit set in `in_svc_o`. On a take, the matching in-service bit is set. In the cycle after the take, `irq_o` is 1 for one cycle together with `vec_o` and `lvl_o`.
- R9: A `ret_i` pulse clears the highest set bit of `in_svc_o`. In that same cycle, the take decision uses the in-service state from before the return, and the new bit is merged in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glob_en_i | input | 1 | Global request enable |
| prio_lo_i | input | 6 | Low bit of each group's level |
| prio_hi_i | input | 6 | High bit of each group's level |
| direct_req_i | input | 9 | Direct request lines (map in R6) |
| sub_evt_i | input | 10 | Sub-source event pulses |
| sub_en_i | input | 10 | Sub-source enables |
| sub_clr_i | input | 10 | Sub-source flag clear pulses |
| ret_i | input | 1 | Return-from-interrupt pulse |
| sub_flag_o | output | 10 | Sub-source sticky flags |
| irq_o | output | 1 | Take strobe |
| vec_o | output | 4 | Vector index of the taken source |
| lvl_o | output | 2 | Level of the taken source |
| in_svc_o | output | 4 | In-service level vector |

## Verification
The critical overlap is a return pulse and a new take falling in the same cycle. The bench holds a level-1 and a level-2 service open, then pulses `ret_i` in the same cycle that a level-3 source rises. The expected in-service vector is 1010: the level-2 bit is retired and the level-3 bit is added. A second case pulses the return while a same-level source is still pending. No strobe is expected on the retiring edge, and the take is expected one cycle later. Flag set and clear are also driven in the same cycle, and the flag is expected to stay set.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_GRP    = 6;
  localparam int NUM_LVL    = 4;
  localparam int LVL_W      = $clog2(NUM_LVL);
  localparam int GRP_W      = $clog2(NUM_GRP);
  localparam int VEC_W      = GRP_W + 1;
  localparam int SRC_SLOTS  = 2 * NUM_GRP;
  localparam int NUM_DIRECT = 9;
  localparam int NUM_SUB    = 10;
  localparam int SUB_PER_OR = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_sub_flags.sv
module irq_sub_flags #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] active_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[i] <= 1'b0;
      else if (evt_i[i])  flag_o[i] <= 1'b1;  // event beats clear
      else if (clr_i[i])  flag_o[i] <= 1'b0;
    end
    assign active_o[i] = flag_o[i] & en_i[i];
  end
endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb #(
  parameter int N_GRP = 6,
  parameter int LVL_W = 2,
  localparam int GW   = $clog2(N_GRP)
) (
  input  logic [N_GRP-1:0]            req_i,
  input  logic [N_GRP-1:0][LVL_W-1:0] lvl_i,
  output logic                        valid_o,
  output logic [GW-1:0]               grp_o,
  output logic [LVL_W-1:0]            lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    grp_o   = '0;
    lvl_o   = '0;
    // strict compare keeps the lower group on a tie
    for (int g = 0; g < N_GRP; g++) begin
      if (req_i[g] && (!valid_o || lvl_i[g] > lvl_o)) begin
        valid_o = 1'b1;
        grp_o   = GW'(g);
        lvl_o   = lvl_i[g];
      end
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track #(
  parameter int N_LVL = 4,
  localparam int LW   = $clog2(N_LVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [LW-1:0]    take_lvl_i,
  input  logic             ret_i,
  output logic [N_LVL-1:0] isr_o,
  output logic             busy_o,
  output logic [LW-1:0]    top_o
);
  logic [N_LVL-1:0] clr_mask, set_mask;

  always_comb begin
    top_o = '0;
    for (int l = 0; l < N_LVL; l++)
      if (isr_o[l]) top_o = LW'(l);
  end

  assign busy_o   = |isr_o;
  assign clr_mask = ret_i  ? (N_LVL'(1) << top_o)      : '0;
  assign set_mask = take_i ? (N_LVL'(1) << take_lvl_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  glob_en_i,
  input  logic [NUM_GRP-1:0]    prio_lo_i,
  input  logic [NUM_GRP-1:0]    prio_hi_i,
  input  logic [NUM_DIRECT-1:0] direct_req_i,
  input  logic [NUM_SUB-1:0]    sub_evt_i,
  input  logic [NUM_SUB-1:0]    sub_en_i,
  input  logic [NUM_SUB-1:0]    sub_clr_i,
  input  logic                  ret_i,
  output logic [NUM_SUB-1:0]    sub_flag_o,
  output logic                  irq_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [LVL_W-1:0]      lvl_o,
  output logic [NUM_LVL-1:0]    in_svc_o
);
  logic [NUM_SUB-1:0]              sub_act;
  logic [SRC_SLOTS-1:0]            src;
  logic [NUM_GRP-1:0]              grp_req, grp_mem;
  logic [NUM_GRP-1:0][LVL_W-1:0]   grp_lvl;
  logic                            win_valid, isr_busy, take;
  logic [GRP_W-1:0]                win_grp;
  lvl_t                            win_lvl, isr_top;

  irq_sub_flags #(.N(NUM_SUB)) u_flags (
    .clk_i, .rst_ni,
    .evt_i(sub_evt_i), .clr_i(sub_clr_i), .en_i(sub_en_i),
    .flag_o(sub_flag_o), .active_o(sub_act)
  );

  // slot index equals vector index
  assign src[0]  = direct_req_i[0];
  assign src[1]  = direct_req_i[1];
  assign src[2]  = direct_req_i[2];
  assign src[3]  = |sub_act[2*SUB_PER_OR-1:SUB_PER_OR];
  assign src[4]  = direct_req_i[3];
  assign src[5]  = direct_req_i[4];
  assign src[6]  = direct_req_i[5];
  assign src[7]  = direct_req_i[6];
  assign src[8]  = direct_req_i[7];
  assign src[9]  = direct_req_i[8] | (|sub_act[NUM_SUB-1:2*SUB_PER_OR]);
  assign src[10] = |sub_act[SUB_PER_OR-1:0];
  assign src[11] = 1'b0;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_req[g] = src[2*g] | src[2*g+1];
    assign grp_mem[g] = ~src[2*g];
    assign grp_lvl[g] = {prio_hi_i[g], prio_lo_i[g]};
  end

  irq_lvl_arb #(.N_GRP(NUM_GRP), .LVL_W(LVL_W)) u_arb (
    .req_i(grp_req), .lvl_i(grp_lvl),
    .valid_o(win_valid), .grp_o(win_grp), .lvl_o(win_lvl)
  );

  assign take = glob_en_i & win_valid & (!isr_busy || win_lvl > isr_top);

  irq_isr_track #(.N_LVL(NUM_LVL)) u_isr (
    .clk_i, .rst_ni,
    .take_i(take), .take_lvl_i(win_lvl), .ret_i,
    .isr_o(in_svc_o), .busy_o(isr_busy), .top_o(isr_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      vec_o <= '0;
      lvl_o <= '0;
    end else begin
      irq_o <= take;
      if (take) begin
        vec_o <= {win_grp, grp_mem[win_grp]};
        lvl_o <= win_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                glob_en_i,
  input logic                ret_i,
  input logic [NUM_SUB-1:0]  sub_evt_i,
  input logic [NUM_SUB-1:0]  sub_clr_i,
  input logic [NUM_SUB-1:0]  sub_flag_o,
  input logic                irq_o,
  input logic [VEC_W-1:0]    vec_o,
  input logic [LVL_W-1:0]    lvl_o,
  input logic [NUM_LVL-1:0]  in_svc_o
);
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sub_evt_i) & ~sub_flag_o) == '0); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sub_flag_o) & ~$past(sub_clr_i) & ~sub_flag_o) == '0); // R3
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vec_o <= VEC_W'(2*NUM_GRP-2)); // R6
  AST_GATED_BY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(glob_en_i)); // R7
  AST_TAKE_MARKS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> in_svc_o[lvl_o]); // R8
  AST_STRICT_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (($past(in_svc_o) >> lvl_o) == '0)); // R8
  AST_RET_NO_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i |=> $countones(in_svc_o) <= $countones($past(in_svc_o))); // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glob_en_i(glob_en_i), .ret_i(ret_i),
  .sub_evt_i(sub_evt_i), .sub_clr_i(sub_clr_i), .sub_flag_o(sub_flag_o),
  .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o), .in_svc_o(in_svc_o)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       glob_en_i = 1'b0;
  logic [5:0] prio_lo_i = '0, prio_hi_i = '0;
  logic [8:0] direct_req_i = '0;
  logic [9:0] sub_evt_i = '0, sub_en_i = '0, sub_clr_i = '0;
  logic       ret_i = 1'b0;
  logic [9:0] sub_flag_o;
  logic       irq_o;
  logic [3:0] vec_o;
  logic [1:0] lvl_o;
  logic [3:0] in_svc_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk_i = ~clk_i;

  irq_prio_ctrl u_dut (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  function automatic int dir2vec(input int b);
    return (b < 3) ? b : b + 1;
  endfunction

  // reference arbiter: scan levels high to low, groups low to high
  function automatic void model(input logic [11:0] s, input logic [5:0] lo, input logic [5:0] hi,
                                output int vec, output int lvl);
    vec = -1; lvl = -1;
    for (int l = 3; l >= 0 && vec < 0; l--)
      for (int g = 0; g < 6 && vec < 0; g++)
        if ((hi[g] * 2 + lo[g]) == l && (s[2*g] || s[2*g+1])) begin
          vec = s[2*g] ? 2*g : 2*g + 1;
          lvl = l;
        end
  endfunction

  task automatic retire();
    direct_req_i = '0; ret_i = 1'b1; step();
    ret_i = 1'b0;
    chk("R9", in_svc_o, 0);
  endtask

  initial begin
    step(); step();
    chk("R1", irq_o, 0);
    chk("R1", in_svc_o, 0);
    chk("R1", sub_flag_o, 0);
    rst_ni = 1'b1; step();
    glob_en_i = 1'b1;

    // single direct source at every uniform level
    for (int l = 0; l < 4; l++) begin
      prio_lo_i = {6{l[0]}}; prio_hi_i = {6{l[1]}};
      for (int b = 0; b < 9; b++) begin
        direct_req_i = 9'(1 << b); step();
        chk("R6", irq_o, 1);
        chk("R6", vec_o, dir2vec(b));
        chk("R5", lvl_o, l);
        chk("R8", in_svc_o, 1 << l);
        retire();
      end
    end

    // sweep of level maps against mixed request masks
    for (int p = 0; p < 64; p++) begin
      logic [8:0]  m;
      logic [11:0] s;
      int ev, el;
      prio_lo_i = 6'(p); prio_hi_i = 6'((p * 37) % 64);
      m = 9'((p * 73 + 5) % 512) | 9'(1 << (p % 9));
      s = '0;
      for (int b = 0; b < 9; b++) s[dir2vec(b)] = m[b];
      model(s, prio_lo_i, prio_hi_i, ev, el);
      direct_req_i = m; step();
      chk("R5", irq_o, 1);
      chk("R6", vec_o, ev);
      chk("R5", lvl_o, el);
      retire();
    end

    // nesting: g0 lvl1, g1 lvl2, g3 lvl3
    prio_lo_i = 6'b001001; prio_hi_i = 6'b001010;
    direct_req_i = 9'b000000001; step();
    chk("R8", irq_o, 1); chk("R8", vec_o, 0); chk("R8", in_svc_o, 4'b0010);
    step();
    chk("R8", irq_o, 0); chk("R8", in_svc_o, 4'b0010);
    direct_req_i = 9'b000000101; step();
    chk("R8", irq_o, 1); chk("R8", vec_o, 2); chk("R8", in_svc_o, 4'b0110);
    direct_req_i = 9'b000100001; ret_i = 1'b1; step();
    ret_i = 1'b0; direct_req_i = 9'b000000001;
    chk("R9", irq_o, 1); chk("R9", vec_o, 6); chk("R9", lvl_o, 3);
    chk("R9", in_svc_o, 4'b1010);
    ret_i = 1'b1; step();
    chk("R9", in_svc_o, 4'b0010); chk("R9", irq_o, 0);
    ret_i = 1'b0; step();
    chk("R8", irq_o, 0);
    ret_i = 1'b1; step();
    ret_i = 1'b0;
    chk("R9", in_svc_o, 4'b0000); chk("R9", irq_o, 0);
    step();
    chk("R9", irq_o, 1); chk("R9", vec_o, 0);
    retire();

    // global enable gate
    prio_lo_i = '0; prio_hi_i = '0;
    glob_en_i = 1'b0; direct_req_i = 9'b000010000;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7", irq_o, 0); chk("R7", in_svc_o, 0);
    end
    glob_en_i = 1'b1; step();
    chk("R7", irq_o, 1); chk("R7", vec_o, 5);
    retire();

    // enables with no flags give no request
    sub_en_i = '1; step(); step();
    chk("R4", irq_o, 0); chk("R4", in_svc_o, 0);
    sub_en_i = '0;

    // sub-source flags
    for (int i = 0; i < 10; i++) begin
      int ev;
      ev = (i < 4) ? 10 : (i < 8) ? 3 : 9;
      sub_evt_i = 10'(1 << i); step();
      sub_evt_i = '0;
      chk("R2", sub_flag_o, 1 << i);
      chk("R4", irq_o, 0);
      step(); step();
      chk("R3", sub_flag_o, 1 << i);
      chk("R4", irq_o, 0); chk("R4", in_svc_o, 0);
      sub_en_i = 10'(1 << i); step();
      chk("R4", irq_o, 1); chk("R4", vec_o, ev);
      sub_en_i = '0; sub_clr_i = 10'(1 << i); ret_i = 1'b1; step();
      sub_clr_i = '0; ret_i = 1'b0;
      chk("R3", sub_flag_o, 0); chk("R9", in_svc_o, 0);
      sub_evt_i = 10'(1 << i); sub_clr_i = 10'(1 << i); step();
      sub_evt_i = '0; sub_clr_i = '0;
      chk("R2", sub_flag_o, 1 << i);
      sub_clr_i = 10'(1 << i); step();
      sub_clr_i = '0;
      chk("R3", sub_flag_o, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule